// File: doc/BRIEF.md
# Phase-Sliced Dual-CPU SRAM Arbiter

Two 8-bit processor ports share one single-port asynchronous SRAM by taking turns inside every processor cycle. A master clock runs at four ticks per processor cycle. The first half of the cycle belongs to port A and the second half to port B. Each half has a setup tick, during which address and data settle, and a strobe tick, during which output-enable or write-enable is asserted. The block multiplexes address, write data and direction onto the SRAM. It keeps chip select permanently active and raises one clock-enable per port, in that port's strobe tick only. The two enables can never overlap, and a setup tick with neither enable high always separates them.

Each port can assert an active-low read-modify-write lock. The first port to lock takes ownership, and the other port's slot is then skipped, with no strobe and no clock-enable, until the lock is dropped. A locked sequence therefore cannot be split. Read data is captured into a per-port holding register at the end of the port's strobe tick. The processor reads that register.

The processor ports are plain, not valid/ready, because the time slicing itself is the flow control. The clock-enable is the only back-pressure. A port whose enable stays low in its slot has been held, and it must keep address, write data, direction and lock unchanged until its enable fires.

Top module: `phase_slot_arbiter`

## Requirements
- R1: While reset is low, both clock-enables are 0, output-enable and write-enable are 1 (inactive), and the data bus is not driven. After release, the first slot is port A's: its setup tick is the current state and its strobe follows one edge later.
- R2: Ticks run 0,1,2,3 repeatedly. Ticks 0 and 1 are port A's setup and strobe, and ticks 2 and 3 are port B's setup and strobe. The SRAM address and write data always show the inputs of the port that owns the current tick.
- R3: `a_ce` is high only in a granted A strobe tick, and `b_ce` only in a granted B strobe tick. They are never high together, and a tick with both low separates any two enable pulses.
- R4: In a granted write slot, write-enable is low and `sram_dq_oe` is 1 only during the strobe tick, and `sram_wdata` carries that port's data. Outside that tick, write-enable is high and the bus is not driven.
- R5: In a granted read slot, output-enable is low only during the strobe tick. Output-enable and write-enable are never low at the same time.
- R6: A port's read-data register loads `sram_rdata` at the end of that port's granted read strobe tick and holds its value at all other times.
- R7: `sram_cs_n` is always 0.
- R8: While port A owns the lock, port B's slot is skipped: no strobe, no `b_ce`, and `b_rdata` is unchanged. The same applies with the roles of A and B exchanged.
- R9: A held port is granted again in its next regular slot once the owner's lock input is high at that slot's setup tick.
- R10: Ownership passes only through the free state. When the lock is free and both lock inputs are low, port A wins.
- R11: A write by A and a read of the same address by B in the same processor cycle return A's new data to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four ticks per processor cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_lock_n | input | 1 | Port A read-modify-write lock, active low |
| a_rdata | output | DATA_W | Port A read holding register |
| a_ce | output | 1 | Port A processor clock-enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_wr | input | 1 | Port B direction, 1 = write |
| b_lock_n | input | 1 | Port B read-modify-write lock, active low |
| b_rdata | output | DATA_W | Port B read holding register |
| b_ce | output | 1 | Port B processor clock-enable |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Drive enable for the SRAM data bus |
| sram_rdata | input | DATA_W | Data returned by the SRAM |
| sram_cs_n | output | 1 | SRAM chip select, held active |
| sram_oe_n | output | 1 | SRAM output-enable, active low |
| sram_we_n | output | 1 | SRAM write-enable, active low |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 8. The 64-word space is small enough that random traffic from both ports often hits the same address, so cross-port read-after-write and lock contention occur often. The narrow address also keeps the bench's SRAM model and its reference copy small. The lock inputs are asserted often enough to reach simultaneous claims, hand-overs through the free state and long holds.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int PORTS  = 2;
  localparam int TICK_W = 2;

  typedef logic [TICK_W-1:0] tick_t;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;

  // the low bit selects setup (0) or strobe (1); the high bit picks the port
  function automatic logic is_setup(tick_t t);
    return ~t[0];
  endfunction

  function automatic logic slot_of(tick_t t);
    return t[TICK_W-1];
  endfunction
endpackage

// File: rtl/pia_phase_seq.sv
module pia_phase_seq
  import pia_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output tick_t tick
);
  tick_t tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_q + tick_t'(1);
  end

  assign tick = tick_q;

  // R2
  tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tick_q == tick_t'($past(tick_q) + tick_t'(1)));
endmodule

// File: rtl/pia_lock_ctrl.sv
module pia_lock_ctrl
  import pia_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] lock_n,
  output owner_e           owner_nxt
);
  owner_e owner_q;

  always_comb begin
    unique case (owner_q)
      OWN_A:   owner_nxt = lock_n[0] ? OWN_NONE : OWN_A;
      OWN_B:   owner_nxt = lock_n[1] ? OWN_NONE : OWN_B;
      default: begin
        if (!lock_n[0])      owner_nxt = OWN_A;
        else if (!lock_n[1]) owner_nxt = OWN_B;
        else                 owner_nxt = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_nxt;
  end

  // R10
  a_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owner_q == OWN_A |=> owner_q != OWN_B);
  // R10
  b_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owner_q == OWN_B |=> owner_q != OWN_A);
  // R10
  a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE && lock_n == '0) |=> owner_q == OWN_A);
endmodule

// File: rtl/pia_slot_engine.sv
module pia_slot_engine
  import pia_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  tick_t                        tick,
  input  owner_e                       owner_nxt,
  input  logic [PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [PORTS-1:0][DATA_W-1:0] wdata,
  input  logic [PORTS-1:0]             wr,
  input  logic [DATA_W-1:0]            sram_rdata,
  output logic [ADDR_W-1:0]            sram_addr,
  output logic [DATA_W-1:0]            sram_wdata,
  output logic                         sram_dq_oe,
  output logic                         sram_oe_n,
  output logic                         sram_we_n,
  output logic [PORTS-1:0]             cpu_ce,
  output logic [PORTS-1:0][DATA_W-1:0] rdata
);
  logic slot;
  logic setup;
  logic blocked;
  logic grant_now;
  logic wr_act_q;
  logic rd_act_q;
  logic [PORTS-1:0]             ce_q;
  logic [PORTS-1:0][DATA_W-1:0] rdata_q;

  assign slot      = slot_of(tick);
  assign setup     = is_setup(tick);
  assign blocked   = slot ? (owner_nxt == OWN_A) : (owner_nxt == OWN_B);
  assign grant_now = setup && !blocked;

  // the multiplexer select follows the slot, and so the master clock
  assign sram_addr  = addr[slot];
  assign sram_wdata = wdata[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      wr_act_q <= grant_now && wr[slot];
      rd_act_q <= grant_now && !wr[slot];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) ce_q[p] <= 1'b0;
      else        ce_q[p] <= grant_now && (slot == 1'(p));
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                            rdata_q[p] <= '0;
      else if (rd_act_q && slot == 1'(p))    rdata_q[p] <= sram_rdata;
    end

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_act_q && slot == 1'(p)) |=> $stable(rdata_q[p]));
    // R3
    ce_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_q[p] |-> (!setup && slot == 1'(p)));
  end

  assign sram_dq_oe = wr_act_q;
  assign sram_we_n  = ~wr_act_q;
  assign sram_oe_n  = ~rd_act_q;
  assign cpu_ce     = ce_q;
  assign rdata      = rdata_q;

  // R5
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));
  // R3
  ce_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce_q[0] && ce_q[1]));
  // R3
  ce_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q != '0) |=> ce_q == '0);
  // R4
  we_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !setup);
  // R8
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup && slot && owner_nxt == OWN_A) |=> (!ce_q[1] && sram_oe_n && sram_we_n));
  // R8
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup && !slot && owner_nxt == OWN_B) |=> (!ce_q[0] && sram_oe_n && sram_we_n));
endmodule

// File: rtl/phase_slot_arbiter.sv
module phase_slot_arbiter
  import pia_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_wr,
  input  logic              a_lock_n,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_ce,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_wr,
  input  logic              b_lock_n,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_ce,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  tick_t                        tick;
  owner_e                       owner_nxt;
  logic [PORTS-1:0][ADDR_W-1:0] addr_v;
  logic [PORTS-1:0][DATA_W-1:0] wdata_v;
  logic [PORTS-1:0][DATA_W-1:0] rdata_v;
  logic [PORTS-1:0]             wr_v;
  logic [PORTS-1:0]             lock_v;
  logic [PORTS-1:0]             ce_v;

  assign addr_v  = {b_addr, a_addr};
  assign wdata_v = {b_wdata, a_wdata};
  assign wr_v    = {b_wr, a_wr};
  assign lock_v  = {b_lock_n, a_lock_n};

  pia_phase_seq i_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  pia_lock_ctrl i_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_n    (lock_v),
    .owner_nxt (owner_nxt)
  );

  pia_slot_engine #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .owner_nxt  (owner_nxt),
    .addr       (addr_v),
    .wdata      (wdata_v),
    .wr         (wr_v),
    .sram_rdata (sram_rdata),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_dq_oe (sram_dq_oe),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .cpu_ce     (ce_v),
    .rdata      (rdata_v)
  );

  // chip select stays active; access is controlled only by the two strobes
  assign sram_cs_n = 1'b0;
  assign a_ce      = ce_v[0];
  assign b_ce      = ce_v[1];
  assign a_rdata   = rdata_v[0];
  assign b_rdata   = rdata_v[1];
endmodule

// File: tb/test_phase_slot_arbiter.sv
`timescale 1ns/1ps
module test_phase_slot_arbiter;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic a_wr = 1'b0, b_wr = 1'b0, a_lock_n = 1'b1, b_lock_n = 1'b1;
  logic [DW-1:0] a_rdata, b_rdata, sram_wdata, sram_rdata;
  logic [AW-1:0] sram_addr;
  logic a_ce, b_ce, sram_dq_oe, sram_cs_n, sram_oe_n, sram_we_n;

  always #5 clk = ~clk;

  phase_slot_arbiter #(.ADDR_W(AW), .DATA_W(DW)) i_phase_slot_arbiter (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_wr(a_wr), .a_lock_n(a_lock_n),
    .a_rdata(a_rdata), .a_ce(a_ce),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_wr(b_wr), .b_lock_n(b_lock_n),
    .b_rdata(b_rdata), .b_ce(b_ce),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_dq_oe(sram_dq_oe),
    .sram_rdata(sram_rdata), .sram_cs_n(sram_cs_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  // behavioural SRAM: write latched at the end of the write strobe
  logic [DW-1:0] sram_mem [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) sram_mem[i] = '0;
  always @(posedge clk) if (!sram_we_n) sram_mem[sram_addr] <= sram_wdata;
  assign sram_rdata = !sram_oe_n ? sram_mem[sram_addr] : '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] ex_ra = '0, ex_rb = '0;
  int ref_owner = 0;  // 0 free, 1 A, 2 B

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int owner_step(int o, logic la_n, logic lb_n);
    if (o == 1) return la_n ? 0 : 1;
    if (o == 2) return lb_n ? 0 : 2;
    if (!la_n) return 1;
    if (!lb_n) return 2;
    return 0;
  endfunction

  // called at a negedge in port A's setup tick; returns there one cycle later
  task automatic run_cycle(
    input logic [AW-1:0] aa, input logic aw, input logic [DW-1:0] ad, input logic al,
    input logic [AW-1:0] ba, input logic bw, input logic [DW-1:0] bd, input logic bl,
    output bit ga, output bit gb);
    int o [4];
    a_addr = aa; a_wr = aw; a_wdata = ad; a_lock_n = al;
    b_addr = ba; b_wr = bw; b_wdata = bd; b_lock_n = bl;
    o[0] = owner_step(ref_owner, al, bl);
    for (int t = 1; t < 4; t++) o[t] = owner_step(o[t-1], al, bl);
    ga = (o[0] != 2);
    gb = (o[2] != 1);
    ref_owner = o[3];
    #1;
    // tick 0: A setup
    chk("R2", 32'(sram_addr), 32'(aa));
    chk("R3", {a_ce, b_ce}, 2'b00);
    chk("R5", {sram_oe_n, sram_we_n}, 2'b11);
    chk("R6", 32'(b_rdata), 32'(ex_rb));
    chk("R7", 32'(sram_cs_n), 0);
    // tick 1: A strobe
    @(posedge clk); @(negedge clk);
    chk("R3", {a_ce, b_ce}, {ga, 1'b0});
    chk("R4", {sram_we_n, sram_dq_oe}, {!(ga && aw), ga && aw});
    chk("R5", 32'(sram_oe_n), 32'(!(ga && !aw)));
    chk("R2", 32'(sram_addr), 32'(aa));
    if (ga && aw) chk("R4", 32'(sram_wdata), 32'(ad));
    if (ga && aw)  ref_mem[aa] = ad;
    if (ga && !aw) ex_ra = ref_mem[aa];
    // tick 2: B setup
    @(posedge clk); @(negedge clk);
    chk("R6", 32'(a_rdata), 32'(ex_ra));
    chk("R3", {a_ce, b_ce}, 2'b00);
    chk("R5", {sram_oe_n, sram_we_n}, 2'b11);
    chk("R2", 32'(sram_addr), 32'(ba));
    // tick 3: B strobe
    @(posedge clk); @(negedge clk);
    chk(gb ? "R3" : "R8", {a_ce, b_ce}, {1'b0, gb});
    chk(gb ? "R4" : "R8", 32'(sram_we_n), 32'(!(gb && bw)));
    chk(gb ? "R5" : "R8", 32'(sram_oe_n), 32'(!(gb && !bw)));
    chk("R2", 32'(sram_addr), 32'(ba));
    if (gb && bw) chk("R4", 32'(sram_wdata), 32'(bd));
    if (gb && bw)  ref_mem[ba] = bd;
    if (gb && !bw) ex_rb = ref_mem[ba];
    @(posedge clk); @(negedge clk);
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit ga, gb;
    int seed;
    logic [AW-1:0] ra, rb;
    logic rwa, rwb, rla, rlb;
    logic [DW-1:0] rda, rdb, old9;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1", {a_ce, b_ce}, 2'b00);
      chk("R1", {sram_oe_n, sram_we_n, sram_dq_oe}, 3'b110);
    end
    rst_n = 1'b1;

    // R1: first slot goes to A
    run_cycle(6'd5, 1'b1, 8'h11, 1'b1, 6'd5, 1'b0, 8'h00, 1'b1, ga, gb);
    chk("R1", ga, 1'b1);
    // R11: A writes, B reads the same address in the same cycle
    chk("R11", 32'(ex_rb), 32'h11);
    run_cycle(6'd5, 1'b0, 8'h00, 1'b1, 6'd5, 1'b1, 8'h22, 1'b1, ga, gb);
    run_cycle(6'd5, 1'b0, 8'h00, 1'b1, 6'd7, 1'b0, 8'h00, 1'b1, ga, gb);
    chk("R11", 32'(a_rdata), 32'h22);

    // locked increment by A while B tries to write the same word
    run_cycle(6'd9, 1'b1, 8'h40, 1'b1, 6'd1, 1'b0, 8'h00, 1'b1, ga, gb);
    run_cycle(6'd9, 1'b0, 8'h00, 1'b0, 6'd9, 1'b1, 8'h77, 1'b1, ga, gb);
    chk("R8", gb, 1'b0);
    old9 = ex_ra;
    chk("R8", 32'(old9), 32'h40);
    run_cycle(6'd9, 1'b1, old9 + 8'd1, 1'b0, 6'd9, 1'b1, 8'h77, 1'b1, ga, gb);
    chk("R8", gb, 1'b0);
    run_cycle(6'd2, 1'b0, 8'h00, 1'b1, 6'd9, 1'b1, 8'h77, 1'b1, ga, gb);
    chk("R9", gb, 1'b1);
    chk("R8", 32'(sram_mem[9]), 32'h77);
    run_cycle(6'd9, 1'b0, 8'h00, 1'b1, 6'd3, 1'b0, 8'h00, 1'b1, ga, gb);
    chk("R8", 32'(a_rdata), 32'h77);

    // R10: both lock from the free state, A wins
    run_cycle(6'd4, 1'b0, 8'h00, 1'b0, 6'd4, 1'b0, 8'h00, 1'b0, ga, gb);
    chk("R10", {ga, gb}, 2'b10);
    // A releases while B still locks: A still runs, then B takes over
    run_cycle(6'd4, 1'b0, 8'h00, 1'b1, 6'd4, 1'b0, 8'h00, 1'b0, ga, gb);
    chk("R10", {ga, gb}, 2'b11);
    run_cycle(6'd4, 1'b1, 8'h5a, 1'b1, 6'd4, 1'b0, 8'h00, 1'b0, ga, gb);
    chk("R8", {ga, gb}, 2'b01);
    run_cycle(6'd4, 1'b1, 8'h5a, 1'b1, 6'd4, 1'b0, 8'h00, 1'b1, ga, gb);
    chk("R9", {ga, gb}, 2'b11);

    // constrained random traffic; a held port keeps its request
    ra = '0; rb = '0; rwa = 0; rwb = 0; rla = 1; rlb = 1; rda = '0; rdb = '0;
    ga = 1; gb = 1;
    for (int c = 0; c < 250; c++) begin
      if (ga) begin
        ra = AW'($urandom_range(0, DEPTH-1)); rwa = 1'($urandom);
        rda = DW'($urandom); rla = ($urandom_range(0, 3) != 0);
      end
      if (gb) begin
        rb = AW'($urandom_range(0, DEPTH-1)); rwb = 1'($urandom);
        rdb = DW'($urandom); rlb = ($urandom_range(0, 3) != 0);
      end
      run_cycle(ra, rwa, rda, rla, rb, rwb, rdb, rlb, ga, gb);
    end
    for (int i = 0; i < DEPTH; i++) chk("R4", 32'(sram_mem[i]), 32'(ref_mem[i]));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule